// File: doc/BRIEF.md
# Conversion External Trigger Detector

This block turns a raw external trigger line into clean start requests for a conversion sequence controller. The line is taken from the top bit of the group of digital samples of the analog input pins, brought into the clock domain through a synchroniser chain, and then qualified. An enable bit, a mode bit and a polarity bit decide what counts as a trigger. In edge mode a trigger is a transition into the active level: rising when the polarity bit is 1, falling when it is 0. In level mode a trigger is the active level itself: high when the polarity bit is 1, low when it is 0.

A start request is a pulse one clock cycle long and is only issued while the sequence controller reports itself idle. In edge mode an active edge that arrives while a sequence is running does not start anything. It sets a sticky overrun flag instead, and the flag stays set until the controller strobes the clear input. In level mode the request repeats for as long as the level is held and the controller is idle, so conversions run back to back.

Top module: `trig_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `start_req` and `ovr_flag` are both 0.
- R2: When `trig_en` is 0, no start request is issued and the overrun flag is not set, whatever the trigger line does.
- R3: Edge mode (`trig_level_mode`=0) with `trig_active_high`=1: a 0-to-1 change of the trigger line, first captured at clock edge k, makes `start_req` 1 for exactly the cycle after edge k+2, provided `seq_busy` is 0 just before edge k+2.
- R4: Edge mode with `trig_active_high`=0: a 1-to-0 change of the trigger line produces one start request with the same latency as in R3, and a 0-to-1 change produces none.
- R5: In edge mode, an active edge that is qualified while `seq_busy` is 1 produces no start request and sets `ovr_flag` in the following cycle.
- R6: `ovr_flag` stays 1 until `ovr_clear` is 1 at a clock edge, and is then 0. When a new overrun and `ovr_clear` occur in the same cycle, the flag ends up at 1.
- R7: Level mode (`trig_level_mode`=1): while the active level is present on the synchronised line, `trig_en` is 1 and `seq_busy` is 0, start requests repeat. No request is issued while `seq_busy` is 1. Level mode never sets `ovr_flag`.
- R8: `start_req` is never 1 in two consecutive cycles.
- R9: In edge mode, a trigger level held active for any length of time yields exactly one start request.
- R10: Only the highest-numbered bit of `ana_pins` (bit NUM_IN-1, bit 7 by default) acts as the trigger. Activity on the lower bits has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ana_pins | input | NUM_IN | Digital samples of the analog input pins; the top bit is the trigger |
| trig_en | input | 1 | 1 enables external triggering |
| trig_level_mode | input | 1 | 0 selects edge triggering, 1 selects level triggering |
| trig_active_high | input | 1 | 1 selects high/rising, 0 selects low/falling |
| seq_busy | input | 1 | 1 while a conversion sequence is running |
| ovr_clear | input | 1 | One-cycle strobe that clears the overrun flag |
| start_req | output | 1 | One-cycle request to start a sequence |
| ovr_flag | output | 1 | Sticky trigger-overrun error |

## Verification
The block keeps only a little state: the synchroniser stages, the remembered previous active level, the mask on the last pulse, and the overrun flag. A wrong value in any of these shows at the ports within three cycles. A bad synchroniser or previous-level value gives a missing, extra or shifted start pulse. A bad pulse mask gives two requests back to back. A bad flag shows as an overrun that either appears or survives a clear. The bench predicts both outputs every cycle with a behavioural model, so it reports any such deviation in the cycle it first appears.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic {
    TRG_EDGE  = 1'b0,
    TRG_LEVEL = 1'b1
  } trg_mode_e;

  // Map the synchronised line onto "active" for the selected polarity.
  function automatic logic active_of(input logic line, input logic high_active);
    return high_active ? line : ~line;
  endfunction

  // Entry into the active level: active now, not active before.
  function automatic logic entered(input logic now_act, input logic prev_act);
    return now_act & ~prev_act;
  endfunction

  // Next state of the sticky flag: a set has priority over a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/trig_qualify.sv
module trig_qualify
  import trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_sync,
  input  logic      en,
  input  trg_mode_e mode,
  input  logic      high_active,
  input  logic      busy,
  output logic      start_req,
  output logic      edge_evt,
  output logic      act_now
);

  logic act_prev;
  logic hit;
  logic start_nxt;

  assign act_now = active_of(line_sync, high_active);
  assign edge_evt = entered(act_now, act_prev);

  always_comb begin
    unique case (mode)
      TRG_LEVEL: hit = act_now;
      default:   hit = edge_evt;
    endcase
  end

  // Mask the cycle right after a pulse so the controller has time to raise busy.
  assign start_nxt = en & hit & ~busy & ~start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev  <= 1'b1;  // treated as already active: no edge out of reset
      start_req <= 1'b0;
    end else begin
      act_prev  <= act_now;
      start_req <= start_nxt;
    end
  end

endmodule

// File: rtl/trig_overrun.sv
module trig_overrun
  import trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= sticky_next(flag, set, clr);
  end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int NUM_IN      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] ana_pins,
  input  logic              trig_en,
  input  logic              trig_level_mode,
  input  logic              trig_active_high,
  input  logic              seq_busy,
  input  logic              ovr_clear,
  output logic              start_req,
  output logic              ovr_flag
);

  localparam int TRIG_IDX = NUM_IN - 1;

  trg_mode_e mode;
  logic      line_sync;
  logic      edge_evt;
  logic      act_now;
  logic      ovr_set;

  assign mode = trg_mode_e'(trig_level_mode);

  trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ana_pins[TRIG_IDX]),
    .q_sync  (line_sync)
  );

  trig_qualify i_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_sync   (line_sync),
    .en          (trig_en),
    .mode        (mode),
    .high_active (trig_active_high),
    .busy        (seq_busy),
    .start_req   (start_req),
    .edge_evt    (edge_evt),
    .act_now     (act_now)
  );

  assign ovr_set = trig_en & (mode == TRG_EDGE) & edge_evt & seq_busy;

  trig_overrun i_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovr_set),
    .clr   (ovr_clear),
    .flag  (ovr_flag)
  );

endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_en,
  input logic trig_level_mode,
  input logic seq_busy,
  input logic ovr_clear,
  input logic start_req,
  input logic ovr_flag,
  input logic edge_evt,
  input logic ovr_set
);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  p_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(trig_en));

  p_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !$past(seq_busy));

  p_edge_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !$past(trig_level_mode)) |-> $past(edge_evt));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clear) |=> ovr_flag);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_flag);

  p_level_no_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> !$past(trig_level_mode));

endmodule

bind trig_detect trig_detect_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .trig_en         (trig_en),
  .trig_level_mode (trig_level_mode),
  .seq_busy        (seq_busy),
  .ovr_clear       (ovr_clear),
  .start_req       (start_req),
  .ovr_flag        (ovr_flag),
  .edge_evt        (edge_evt),
  .ovr_set         (ovr_set)
);

// File: tb/test_trig_detect.sv
`timescale 1ns/1ps
module test_trig_detect;

  localparam int NUM_IN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IN-1:0] ana_pins = '0;
  logic trig_en = 1'b0, trig_level_mode = 1'b0, trig_active_high = 1'b1;
  logic seq_busy = 1'b0, ovr_clear = 1'b0;
  logic start_req, ovr_flag;

  int n_checks = 0;
  int n_errors = 0;
  int pulses = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trig_detect #(.NUM_IN(NUM_IN), .SYNC_STAGES(2)) i_trig_detect (
    .clk(clk), .rst_n(rst_n), .ana_pins(ana_pins), .trig_en(trig_en),
    .trig_level_mode(trig_level_mode), .trig_active_high(trig_active_high),
    .seq_busy(seq_busy), .ovr_clear(ovr_clear),
    .start_req(start_req), .ovr_flag(ovr_flag)
  );

  task automatic check_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: a queue stands for the two-cycle delay of the line.
  logic line_q[$] = '{1'b0, 1'b0};
  bit m_was_active = 1'b1;
  bit m_start = 1'b0, m_ovr = 1'b0, m_prev_start = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      line_q = '{1'b0, 1'b0};
      m_was_active = 1'b1;
      m_start = 1'b0;
      m_ovr = 1'b0;
    end else begin
      bit seen, is_active, is_entry, want;
      seen = line_q[0];
      is_active = (seen == trig_active_high);
      is_entry = is_active && !m_was_active;
      want = trig_level_mode ? is_active : is_entry;
      if (trig_en && !trig_level_mode && is_entry && seq_busy) m_ovr = 1'b1;
      else if (ovr_clear) m_ovr = 1'b0;
      m_start = trig_en && want && !seq_busy && !m_start;
      m_was_active = is_active;
      void'(line_q.pop_front());
      line_q.push_back(ana_pins[NUM_IN-1]);
    end
  end

  // Compare every cycle, away from the clock edge; R8 checked on the ports.
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check_bit("R3/R5 start_req vs model", start_req, m_start);
      check_bit("R6 ovr_flag vs model", ovr_flag, m_ovr);
      if (start_req === 1'b1 && m_prev_start) check_bit("R8 back-to-back pulse", 1'b1, 1'b0);
      m_prev_start = (start_req === 1'b1);
      if (start_req === 1'b1) pulses++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_trig(logic v);
    @(negedge clk);
    ana_pins[NUM_IN-1] = v;
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(3);
    #1 check_bit("R1 start_req in reset", start_req, 1'b0);
    check_bit("R1 ovr_flag in reset", ovr_flag, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #2;
    check_bit("R1 start_req after reset", start_req, 1'b0);
    check_bit("R1 ovr_flag after reset", ovr_flag, 1'b0);

    // R2: disabled, line toggling
    pulses = 0;
    for (int i = 0; i < 6; i++) begin set_trig(1'b1); cyc(2); set_trig(1'b0); cyc(2); end
    cyc(4);
    check_int("R2 pulses while disabled", pulses, 0);
    check_bit("R2 no overrun while disabled", ovr_flag, 1'b0);

    // R3: rising edge, exact latency
    trig_en = 1'b1; trig_active_high = 1'b1; trig_level_mode = 1'b0;
    cyc(4);
    @(negedge clk) ana_pins[NUM_IN-1] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk) #2;
    check_bit("R3 pulse after third edge", start_req, 1'b1);
    @(posedge clk) #2;
    check_bit("R3 pulse lasts one cycle", start_req, 1'b0);

    // R9: held level gives one pulse only
    pulses = 0;
    cyc(20);
    check_int("R9 pulses for held level", pulses, 0);
    set_trig(1'b0); cyc(5);
    check_int("R3 falling edge ignored when active high", pulses, 0);

    // R4: falling polarity
    trig_active_high = 1'b0;
    cyc(4);
    pulses = 0;
    set_trig(1'b1); cyc(5);
    check_int("R4 rising edge ignored when active low", pulses, 0);
    @(negedge clk) ana_pins[NUM_IN-1] = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk) #2;
    check_bit("R4 falling edge pulse", start_req, 1'b1);
    cyc(5);
    check_int("R4 one pulse", pulses, 1);

    // R10: lower bits have no effect
    trig_active_high = 1'b1;
    cyc(4);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) ana_pins[NUM_IN-2:0] = ~ana_pins[NUM_IN-2:0];
      cyc(2);
    end
    cyc(4);
    check_int("R10 lower bits ignored", pulses, 0);
    check_bit("R10 no overrun from lower bits", ovr_flag, 1'b0);

    // R5: edge while busy
    seq_busy = 1'b1;
    pulses = 0;
    set_trig(1'b1); cyc(5);
    check_int("R5 no start while busy", pulses, 0);
    check_bit("R5 overrun set", ovr_flag, 1'b1);

    // R6: sticky then clear
    seq_busy = 1'b0; set_trig(1'b0); cyc(10);
    check_bit("R6 flag sticky", ovr_flag, 1'b1);
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    check_bit("R6 flag cleared", ovr_flag, 1'b0);

    // R6: set and clear in the same cycle, set wins
    seq_busy = 1'b1;
    @(negedge clk) ana_pins[NUM_IN-1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    check_bit("R6 set wins over clear", ovr_flag, 1'b1);
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    set_trig(1'b0); seq_busy = 1'b0; cyc(4);

    // R7: level mode, repeats while idle, stops while busy, no overrun
    trig_level_mode = 1'b1;
    pulses = 0;
    set_trig(1'b1); cyc(22);
    check_int("R7 repeated requests while level held", (pulses >= 8) ? 1 : 0, 1);
    seq_busy = 1'b1; cyc(2);
    pulses = 0;
    cyc(10);
    check_int("R7 no request while busy", pulses, 0);
    set_trig(1'b0); cyc(3); set_trig(1'b1); cyc(5);
    check_bit("R7 level mode never sets overrun", ovr_flag, 1'b0);
    seq_busy = 1'b0; trig_active_high = 1'b0;
    pulses = 0;
    cyc(10);
    check_int("R7 active-high level ignored when active low", pulses, 0);
    set_trig(1'b0); cyc(10);
    check_int("R7 low level repeats", (pulses >= 3) ? 1 : 0, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule